// File: doc/BRIEF.md
# PCI Configuration Header Register File

This block holds the 64-byte type-0 configuration header of a single PCI device function. A host-side agent reaches it through a plain register port: an offset, an access size (byte, halfword or word), write data and a write flag, qualified by a valid strobe. Every access is answered one cycle later with a response strobe, read data assembled little-endian from the header image, and an error flag. The block decides which fields accept writes and at which access widths, and it answers the base-address sizing handshake that enumeration software uses to learn how much space each window needs.

Each of the six base-address registers (BARs) has a parameterised power-of-two size. Bit 0 of a BAR's current value marks it as IO space (two low type bits held) or memory space (four low type bits held). When a BAR is programmed with a nonzero address, the block exports the decoded system base of that window (the address plus a per-space offset), sets the window's enable, and pulses a range-change strobe together with the response so that the downstream decode can reload. All reset values, BAR sizes and space offsets are parameters.

Top module: `cfg_header_regs`

## Requirements
- R1: On reset every header field takes its parameter default, all window enables and window bases are zero, and rsp_valid, rsp_error and range_chg are low.
- R2: An access with acc_valid high is answered in the next cycle with rsp_valid high. A read returns 1, 2 or 4 bytes (acc_size 0, 1, 2) from the header image starting at acc_offset, the lowest offset in bits 7:0; bytes past offset 0x3F read as zero; unused upper bytes and all write responses carry zero data. Layout: vendor 0x00, device 0x02, command 0x04, status 0x06, revision 0x08, class 0x09-0x0B, cache-line 0x0C, latency 0x0D, header type 0x0E, self-test 0x0F, BARs 0x10-0x27, cardbus pointer 0x28, subsystem IDs 0x2C/0x2E, ROM base 0x30, interrupt line 0x3C, interrupt pin 0x3D, minimum grant 0x3E, maximum latency 0x3F; 0x34-0x3B read zero.
- R3: Any access with acc_offset at or above 0x40, and any access with acc_size 3, sets rsp_error with zero data and changes no state.
- R4: A word write of 0xFFFFFFFF to a BAR (aligned offset 0x10 + 4n) loads the address bits with ~(size-1) and keeps the type bits (bits 1:0 when bit 0 is 1, bits 3:0 otherwise), so a read returns the size mask with the type bits; the window outputs do not change.
- R5: Any other word write to a BAR stores the data with the type bits replaced by the current ones; if the stored address bits are nonzero the window base becomes those address bits plus the IO or memory space offset, its enable sets, and range_chg is high for one cycle together with the response.
- R6: A BAR write whose address bits are all zero raises no range_chg and leaves that window's base and enable as they were; an enable never clears except by reset.
- R7: A word write of 0xFFFFFFFE to offset 0x30 makes the ROM base read as 0xFFFFFFFF; any other word value there is stored as written.
- R8: The 16-bit command register at 0x04 is loaded from the low 16 bits of a halfword or word write at offset 0x04; the status halfword is unaffected.
- R9: Byte writes to 0x0C, 0x0D and 0x3C each load only their own byte, without error.
- R10: Byte writes to 0x08, 0x0B, 0x3D, 0x3E and 0x3F are accepted without error and change nothing.
- R11: A byte write to any other header offset, or a halfword write to any offset except 0x04, sets rsp_error and changes nothing.
- R12: A word write to a header offset that is not 0x04, 0x30 or an aligned BAR offset is dropped without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_offset | input | OFS_W | Header byte offset |
| acc_wdata | input | 32 | Write data, lowest offset in bits 7:0 |
| rsp_valid | output | 1 | Response strobe, one cycle after acc_valid |
| rsp_rdata | output | 32 | Read data |
| rsp_error | output | 1 | Access rejected |
| win_base | output | 6*32 | Decoded system base per BAR, BAR n in bits 32n+31:32n |
| win_en | output | 6 | Window active per BAR |
| range_chg | output | 1 | One-cycle pulse when a window base is loaded |

## Verification
The bench aims at the sizing handshake on an IO BAR and on a memory BAR with a prefetch type bit set, where a design that masked the wrong number of bits would either corrupt the type field or leave stale size bits in the address. It writes a BAR with only type bits, where a careless design would pulse range_chg or disable a live window, and it walks the width-dependent write policy: the silently ignored bytes, the rejected byte and halfword offsets and the dropped word writes, any of which a wrong decoder would turn into a spurious error or a corrupted field. The ROM all-ones conversion and the misaligned read that runs past 0x3F are also checked against the behavioural model.

// File: rtl/cfg_header_regs.sv
module cfg_header_regs #(
  parameter int          OFS_W        = 8,
  parameter logic [15:0] VENDOR_ID    = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID    = 16'h3C4D,
  parameter logic [15:0] CMD_INIT     = 16'h0000,
  parameter logic [15:0] STATUS_INIT  = 16'h0290,
  parameter logic [7:0]  REVISION     = 8'h01,
  parameter logic [23:0] CLASS_INIT   = 24'h020000,
  parameter logic [7:0]  CLS_INIT     = 8'h00,
  parameter logic [7:0]  LAT_INIT     = 8'h00,
  parameter logic [7:0]  HDR_TYPE     = 8'h00,
  parameter logic [7:0]  SELFTEST     = 8'h00,
  parameter logic [191:0] BAR_INIT    = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h1},
  parameter logic [191:0] BAR_SIZE    = {32'h0, 32'h0, 32'h0, 32'h0010_0000, 32'h1000, 32'h100},
  parameter logic [31:0] CIS_PTR      = 32'h0,
  parameter logic [15:0] SUB_VID      = 16'h0,
  parameter logic [15:0] SUB_ID       = 16'h0,
  parameter logic [31:0] ROM_INIT     = 32'h0,
  parameter logic [7:0]  INTLINE_INIT = 8'h00,
  parameter logic [7:0]  INT_PIN      = 8'h01,
  parameter logic [7:0]  MIN_GNT      = 8'h00,
  parameter logic [7:0]  MAX_LAT      = 8'h00,
  parameter logic [31:0] IO_BASE      = 32'h8000_0000,
  parameter logic [31:0] MEM_BASE     = 32'h4000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [1:0]       acc_size,
  input  logic [OFS_W-1:0] acc_offset,
  input  logic [31:0]      acc_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  output logic             rsp_error,
  output logic [191:0]     win_base,
  output logic [5:0]       win_en,
  output logic             range_chg
);
  localparam int NUM_BARS  = 6;
  localparam int HDR_BYTES = 64;
  localparam int IDX_W     = $clog2(HDR_BYTES);
  localparam logic [31:0] IO_MASK  = 32'h3;
  localparam logic [31:0] MEM_MASK = 32'hF;

  logic [15:0] cmd_q;
  logic [7:0]  cls_q, lat_q, intl_q;
  logic [31:0] rom_q;
  logic [31:0] bar_q  [NUM_BARS];
  logic [31:0] base_q [NUM_BARS];
  logic [NUM_BARS-1:0] en_q;

  logic [7:0]  img [HDR_BYTES];
  logic [31:0] rd_word;
  logic [31:0] bar_msk [NUM_BARS];
  logic [31:0] bar_new [NUM_BARS];
  logic [31:0] bar_win [NUM_BARS];
  logic [NUM_BARS-1:0] bar_hit, bar_live;

  wire out_of_hdr = acc_offset >= OFS_W'(HDR_BYTES);
  wire size_bad   = acc_size == 2'd3;
  wire all_ones   = acc_wdata == 32'hFFFF_FFFF;

  always_comb begin
    for (int i = 0; i < HDR_BYTES; i++) img[i] = 8'h00;
    {img[1], img[0]}   = VENDOR_ID;
    {img[3], img[2]}   = DEVICE_ID;
    {img[5], img[4]}   = cmd_q;
    {img[7], img[6]}   = STATUS_INIT;
    img[8]             = REVISION;
    {img[11], img[10], img[9]} = CLASS_INIT;
    img[12] = cls_q;
    img[13] = lat_q;
    img[14] = HDR_TYPE;
    img[15] = SELFTEST;
    for (int b = 0; b < NUM_BARS; b++)
      for (int k = 0; k < 4; k++) img[16 + 4*b + k] = bar_q[b][8*k +: 8];
    {img[43], img[42], img[41], img[40]} = CIS_PTR;
    {img[45], img[44]} = SUB_VID;
    {img[47], img[46]} = SUB_ID;
    {img[51], img[50], img[49], img[48]} = rom_q;
    img[60] = intl_q;
    img[61] = INT_PIN;
    img[62] = MIN_GNT;
    img[63] = MAX_LAT;
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < 4; k++) begin
      logic [IDX_W:0] idx;
      idx = {1'b0, acc_offset[IDX_W-1:0]} + (IDX_W+1)'(k);
      if (k < (1 << acc_size) && !idx[IDX_W]) rd_word[8*k +: 8] = img[idx[IDX_W-1:0]];
    end
  end

  always_comb begin
    for (int b = 0; b < NUM_BARS; b++) begin
      bar_msk[b] = bar_q[b][0] ? IO_MASK : MEM_MASK;
      bar_hit[b] = acc_offset == OFS_W'(16 + 4*b);
      bar_new[b] = ((all_ones ? ~(BAR_SIZE[32*b +: 32] - 32'd1) : acc_wdata) & ~bar_msk[b])
                   | (bar_q[b] & bar_msk[b]);
      bar_live[b] = !all_ones && ((acc_wdata & ~bar_msk[b]) != 32'd0);
      bar_win[b]  = (acc_wdata & ~bar_msk[b]) + (bar_q[b][0] ? IO_BASE : MEM_BASE);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= CMD_INIT;
      cls_q  <= CLS_INIT;
      lat_q  <= LAT_INIT;
      intl_q <= INTLINE_INIT;
      rom_q  <= ROM_INIT;
      for (int b = 0; b < NUM_BARS; b++) begin
        bar_q[b]  <= BAR_INIT[32*b +: 32];
        base_q[b] <= '0;
      end
      en_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_error <= 1'b0;
      range_chg <= 1'b0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_rdata <= '0;
      rsp_error <= 1'b0;
      range_chg <= 1'b0;
      if (acc_valid) begin
        if (out_of_hdr || size_bad) rsp_error <= 1'b1;
        else if (!acc_write) rsp_rdata <= rd_word;
        else if (acc_size == 2'd0) begin
          case (acc_offset)
            OFS_W'(8'h0C): cls_q  <= acc_wdata[7:0];
            OFS_W'(8'h0D): lat_q  <= acc_wdata[7:0];
            OFS_W'(8'h3C): intl_q <= acc_wdata[7:0];
            OFS_W'(8'h08), OFS_W'(8'h0B), OFS_W'(8'h3D),
            OFS_W'(8'h3E), OFS_W'(8'h3F): ;
            default: rsp_error <= 1'b1;
          endcase
        end else if (acc_size == 2'd1) begin
          if (acc_offset == OFS_W'(8'h04)) cmd_q <= acc_wdata[15:0];
          else rsp_error <= 1'b1;
        end else begin
          if (acc_offset == OFS_W'(8'h04)) cmd_q <= acc_wdata[15:0];
          if (acc_offset == OFS_W'(8'h30))
            rom_q <= (acc_wdata == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : acc_wdata;
          for (int b = 0; b < NUM_BARS; b++) begin
            if (bar_hit[b]) begin
              bar_q[b] <= bar_new[b];
              if (bar_live[b]) begin
                base_q[b] <= bar_win[b];
                en_q[b]   <= 1'b1;
                range_chg <= 1'b1;
              end
            end
          end
        end
      end
    end
  end

  always_comb
    for (int b = 0; b < NUM_BARS; b++) win_base[32*b +: 32] = base_q[b];
  assign win_en = en_q;

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n) acc_valid |=> rsp_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !acc_valid |=> !rsp_valid && !rsp_error && !range_chg); // R2
  AST_HIGH_OFS_ERR: assert property (@(posedge clk) disable iff (!rst_n) acc_valid && out_of_hdr |=> rsp_error && rsp_rdata == 32'd0); // R3
  AST_CHG_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n) range_chg |-> rsp_valid && !rsp_error); // R5
  AST_EN_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n) ($past(en_q) & ~en_q) == '0); // R6
  AST_ROM_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_write && acc_size == 2'd2 && acc_offset == OFS_W'(8'h30) && acc_wdata == 32'hFFFF_FFFE
    |=> rom_q == 32'hFFFF_FFFF); // R7

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar_chk
    AST_TYPE_KEPT: assert property (@(posedge clk) disable iff (!rst_n) $stable(bar_q[g][1:0])); // R4
    AST_MEM_TYPE_KEPT: assert property (@(posedge clk) disable iff (!rst_n) !bar_q[g][0] |=> $stable(bar_q[g][3:2])); // R4
  end
endmodule

// File: tb/tb_cfg_header_regs.sv
module tb_cfg_header_regs;
  localparam logic [191:0] T_BAR_INIT = {32'h0, 32'h0, 32'h0, 32'h0, 32'h8, 32'h1};
  localparam logic [191:0] T_BAR_SIZE = {32'h0, 32'h0, 32'h0, 32'h0010_0000, 32'h1000, 32'h100};
  localparam logic [31:0]  T_IO  = 32'h8000_0000;
  localparam logic [31:0]  T_MEM = 32'h4000_0000;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0;
  logic [1:0] acc_size = 0;
  logic [7:0] acc_offset = 0;
  logic [31:0] acc_wdata = 0;
  logic rsp_valid, rsp_error, range_chg;
  logic [31:0] rsp_rdata;
  logic [191:0] win_base;
  logic [5:0] win_en;

  always #4 clk = ~clk;

  cfg_header_regs #(
    .VENDOR_ID(16'h1A2B), .DEVICE_ID(16'h3C4D), .CMD_INIT(16'h0006), .STATUS_INIT(16'h0290),
    .REVISION(8'h05), .CLASS_INIT(24'h020010), .CLS_INIT(8'h10), .LAT_INIT(8'h20),
    .HDR_TYPE(8'h00), .SELFTEST(8'h00), .BAR_INIT(T_BAR_INIT), .BAR_SIZE(T_BAR_SIZE),
    .CIS_PTR(32'h0), .SUB_VID(16'h1111), .SUB_ID(16'h2222), .ROM_INIT(32'h0),
    .INTLINE_INIT(8'h0B), .INT_PIN(8'h01), .MIN_GNT(8'h03), .MAX_LAT(8'h04),
    .IO_BASE(T_IO), .MEM_BASE(T_MEM)
  ) dut (.*);

  byte unsigned m [64];
  logic [31:0] mbase [6];
  bit men [6];
  int tests = 0, fails = 0;
  bit done = 0;

  function automatic logic [31:0] mword(int o);
    return {m[o+3], m[o+2], m[o+1], m[o]};
  endfunction

  task automatic mset(int o, logic [31:0] v);
    for (int k = 0; k < 4; k++) m[o+k] = v[8*k +: 8];
  endtask

  task automatic model_init();
    for (int i = 0; i < 64; i++) m[i] = 0;
    mset(0, 32'h3C4D_1A2B); mset(4, 32'h0290_0006); mset(8, 32'h0200_1005);
    mset(12, 32'h0000_2010); mset(16, 32'h1); mset(20, 32'h8);
    mset(44, 32'h2222_1111); mset(60, 32'h0403_010B);
    for (int b = 0; b < 6; b++) begin mbase[b] = 0; men[b] = 0; end
  endtask

  task automatic cmp_outputs(string tag, logic e_vld, logic [31:0] e_rd, logic e_err, logic e_chg);
    bit ok;
    tests++;
    ok = (rsp_valid === e_vld) && (rsp_rdata === e_rd) && (rsp_error === e_err) && (range_chg === e_chg);
    for (int b = 0; b < 6; b++)
      if (win_en[b] !== men[b] || win_base[32*b +: 32] !== mbase[b]) ok = 0;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got vld=%0b rd=%h err=%0b chg=%0b en=%b exp vld=%0b rd=%h err=%0b chg=%0b en=%b%b%b%b%b%b",
               tag, rsp_valid, rsp_rdata, rsp_error, range_chg, win_en, e_vld, e_rd, e_err, e_chg,
               men[5], men[4], men[3], men[2], men[1], men[0]);
    end
  endtask

  task automatic acc(bit wr, logic [1:0] sz, int ofs, logic [31:0] wd, string tag);
    logic [31:0] e_rd = 0;
    logic e_err = 0, e_chg = 0;
    int nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    if (ofs >= 64 || sz == 3) e_err = 1;
    else if (!wr) begin
      for (int k = 0; k < nb; k++) if (ofs + k < 64) e_rd[8*k +: 8] = m[ofs+k];
    end else if (sz == 0) begin
      if (ofs inside {12, 13, 60}) m[ofs] = wd[7:0];
      else if (!(ofs inside {8, 11, 61, 62, 63})) e_err = 1;
    end else if (sz == 1) begin
      if (ofs == 4) begin m[4] = wd[7:0]; m[5] = wd[15:8]; end
      else e_err = 1;
    end else begin
      if (ofs == 4) begin m[4] = wd[7:0]; m[5] = wd[15:8]; end
      if (ofs == 48) mset(48, (wd == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : wd);
      if (ofs >= 16 && ofs < 40 && ofs % 4 == 0) begin
        int b = (ofs - 16) / 4;
        logic [31:0] cur = mword(ofs);
        int nt = cur[0] ? 2 : 4;
        logic [31:0] v;
        logic [31:0] addr;
        if (wd == 32'hFFFF_FFFF) v = 32'd0 - T_BAR_SIZE[32*b +: 32];
        else v = wd;
        addr = (v >> nt) << nt;
        v = addr | (cur - ((cur >> nt) << nt));
        mset(ofs, v);
        if (wd != 32'hFFFF_FFFF && addr != 0) begin
          mbase[b] = addr + (cur[0] ? T_IO : T_MEM);
          men[b] = 1;
          e_chg = 1;
        end
      end
    end
    acc_valid = 1; acc_write = wr; acc_size = sz; acc_offset = 8'(ofs); acc_wdata = wd;
    @(negedge clk);
    acc_valid = 0;
    cmp_outputs(tag, 1'b1, e_rd, e_err, e_chg);
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    cmp_outputs(tag, 1'b0, 32'd0, 1'b0, 1'b0);
  endtask

  initial begin
    model_init();
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle("R1 reset outputs");
    acc(0, 2, 8'h00, 0, "R1 R2 ids word");
    acc(0, 1, 8'h02, 0, "R2 device half");
    acc(0, 0, 8'h09, 0, "R2 class byte");
    acc(0, 2, 8'h08, 0, "R1 R2 revision/class word");
    acc(0, 2, 8'h0C, 0, "R1 cache/latency defaults");
    acc(0, 2, 8'h3C, 0, "R1 R2 interrupt word");
    acc(0, 2, 8'h3E, 0, "R2 read past end");
    acc(0, 2, 8'h10, 0, "R1 BAR0 default");
    acc(0, 2, 8'h14, 0, "R1 BAR1 default");
    acc(0, 2, 8'h40, 0, "R3 read above header");
    acc(1, 2, 8'h80, 32'h1234, "R3 write above header");
    acc(0, 3, 8'h00, 0, "R3 bad size");
    acc(1, 2, 8'h10, 32'hFFFF_FFFF, "R4 size IO BAR0");
    acc(0, 2, 8'h10, 0, "R4 IO size mask");
    acc(1, 2, 8'h14, 32'hFFFF_FFFF, "R4 size mem BAR1");
    acc(0, 2, 8'h14, 0, "R4 mem size mask");
    acc(1, 2, 8'h1C, 32'hFFFF_FFFF, "R4 size zero-size BAR3");
    acc(0, 2, 8'h1C, 0, "R4 BAR3 readback");
    acc(1, 2, 8'h10, 32'h0000_1234, "R5 program BAR0");
    acc(0, 2, 8'h10, 0, "R5 BAR0 readback");
    acc(1, 2, 8'h14, 32'h0010_0007, "R5 program BAR1");
    acc(0, 2, 8'h14, 0, "R5 BAR1 readback");
    acc(1, 2, 8'h18, 32'h0000_000E, "R6 BAR2 type-only write");
    acc(1, 2, 8'h10, 32'h0000_0003, "R6 BAR0 zero address");
    acc(0, 2, 8'h10, 0, "R6 BAR0 readback");
    acc(1, 2, 8'h24, 32'hABCD_0000, "R5 program BAR5");
    acc(1, 2, 8'h30, 32'hFFFF_FFFE, "R7 ROM sizing");
    acc(0, 2, 8'h30, 0, "R7 ROM all ones");
    acc(1, 2, 8'h30, 32'h1234_5678, "R7 ROM store");
    acc(0, 2, 8'h30, 0, "R7 ROM readback");
    acc(1, 1, 8'h04, 32'h0000_ABCD, "R8 command half");
    acc(0, 2, 8'h04, 0, "R8 command/status");
    acc(1, 2, 8'h04, 32'h5555_0107, "R8 command word");
    acc(0, 2, 8'h04, 0, "R8 status unchanged");
    acc(1, 0, 8'h0C, 32'h0000_0040, "R9 cache-line byte");
    acc(1, 0, 8'h0D, 32'h0000_00F8, "R9 latency byte");
    acc(1, 0, 8'h3C, 32'h0000_0077, "R9 interrupt line byte");
    acc(0, 2, 8'h0C, 0, "R9 readback 0x0C");
    acc(0, 2, 8'h3C, 0, "R9 R10 readback 0x3C");
    acc(1, 0, 8'h08, 32'hFF, "R10 revision ignored");
    acc(1, 0, 8'h0B, 32'hFF, "R10 class ignored");
    acc(1, 0, 8'h3D, 32'hFF, "R10 pin ignored");
    acc(1, 0, 8'h3E, 32'hFF, "R10 min grant ignored");
    acc(1, 0, 8'h3F, 32'hFF, "R10 max latency ignored");
    acc(0, 2, 8'h08, 0, "R10 readback 0x08");
    acc(0, 2, 8'h3C, 0, "R10 readback 0x3C");
    acc(1, 0, 8'h00, 32'h55, "R11 byte to vendor");
    acc(1, 0, 8'h04, 32'h55, "R11 byte to command");
    acc(1, 1, 8'h0C, 32'h5555, "R11 half to cache-line");
    acc(1, 1, 8'h06, 32'h5555, "R11 half to status");
    acc(0, 2, 8'h04, 0, "R11 command unchanged");
    acc(0, 2, 8'h00, 0, "R11 ids unchanged");
    acc(1, 2, 8'h00, 32'hDEAD_BEEF, "R12 word to ids");
    acc(1, 2, 8'h08, 32'hDEAD_BEEF, "R12 word to class");
    acc(1, 2, 8'h12, 32'hDEAD_BEEF, "R12 misaligned BAR");
    acc(1, 2, 8'h2C, 32'hDEAD_BEEF, "R12 word to subsystem");
    acc(0, 2, 8'h00, 0, "R12 ids readback");
    acc(0, 2, 8'h10, 0, "R12 BAR0 readback");
    acc(0, 2, 8'h2C, 0, "R12 subsystem readback");
    idle("R2 idle after traffic");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule